// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a cycle-accurate synchronous static memory whose bus never idles when it switches between reading and writing. Every command (address, direction, chip selects, advance/load, burst order) is registered on a rising edge. The data belonging to that command moves during the following clock period. So a read can follow a write, or a write a read, on consecutive edges, and each bus cycle carries useful data.

The read path has no output register: once the data cycle opens, the stored word reaches `dout` through logic alone. A built-in two-bit burst counter turns one loaded address into a run of four words, in linear or interleaved order. An active-low clock enable freezes the whole block. Three chip selects gate new commands without cutting off a transfer that is already in flight. The bidirectional pad is modelled as a separate input bus, a separate output bus and an output-valid flag. `dout` is held at zero whenever the flag is low.

Top module: `zt_sram`

## Requirements
- R1: A read command registered at a clock edge with `oe_n` low raises `dout_en` right after that edge. `dout` then shows the addressed word for the rest of that cycle, with no further register on the way.
- R2: A write's data and lane selects are taken on the first enabled edge after its command edge. Lane i (bits [9i+8:9i] by default) is stored only when `lane_wr_n[i]` is 0. The other lanes keep their contents.
- R3: A read loaded on the same edge that completes a write to that address returns the newly written word. Reads and writes alternate on consecutive edges with no idle cycle.
- R4: While `clk_en_n` is 1, every clocked input is ignored, no state changes and the memory is not written. `dout`/`dout_en` keep their values, given a steady `oe_n`.
- R5: A load (`adv_ld`=0) counts as selected only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. An unselected load starts nothing, but a write already pending still completes on that edge.
- R6: `dout_en` is low in the cycle after an unselected load and in the cycle after a write load. `dout` reads zero whenever `dout_en` is low.
- R7: An advance (`adv_ld`=1) during an active burst moves to the next beat address and repeats the burst's read/write type. The chip-select pins are ignored on such an edge.
- R8: With `burst_il`=0 at load, beat k addresses {upper bits of the start address, (start[1:0]+k) mod 4}. Advancing past beat 3 wraps back to beat 0.
- R9: With `burst_il`=1 at load, beat k addresses {upper bits, start[1:0] XOR k}.
- R10: An advance that arrives while no burst is active (after an unselected load) starts nothing and writes nothing.
- R11: `oe_n`=1 forces `dout_en` to 0 and `dout` to 0 at once, without waiting for a clock edge.
- R12: Asynchronous reset (`rst_n`=0) clears any pending transfer and any burst, so `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| rd_wr_n | input | 1 | 1 read, 0 write (sampled on load) |
| burst_il | input | 1 | 0 linear, 1 interleaved burst (sampled on load) |
| lane_wr_n | input | LANES | Active-low per-lane write selects, taken with write data |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data for the pending write |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | DATA_W | Flow-through read data, zero when not driven |
| dout_en | output | 1 | High while `dout` carries read data |

## Verification
On every clock, the checker confirms a set of pin-level timing rules. A write load or an unselected load is followed by a quiet bus. A selected read load is followed by a driven bus unless `oe_n` is high. A frozen edge leaves the outputs unchanged. A high `oe_n` always silences them. Some behaviour depends on what the array holds, and only the bench's scenarios show it: the two burst orders and their wrap, lane-masked writes, a read right after a write to the same word, a pending write that completes through a deselect, and an idle advance that leaves memory untouched.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

   localparam int unsigned BEAT_W      = 2;
   localparam int unsigned BURST_BEATS = 1 << BEAT_W;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } zt_op_e;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } zt_order_e;

   // low address bits of burst beat 'beat' for a burst that began at 'start'
   function automatic logic [BEAT_W-1:0] beat_offset(
      input logic [BEAT_W-1:0] start,
      input logic [BEAT_W-1:0] beat,
      input zt_order_e         ord
   );
      logic [BEAT_W-1:0] res;
      if (ord == ORD_INTERLEAVE) res = start ^ beat;
      else                       res = start + beat;
      return res;
   endfunction

endpackage

// File: rtl/zt_cmd_stage.sv
module zt_cmd_stage
   import zt_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic              sel,
   input  zt_op_e            op_in,
   input  zt_order_e         ord_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              pend_valid,
   output zt_op_e            pend_op,
   output logic [ADDR_W-1:0] pend_addr
);

   logic              burst_act_q;
   logic              pend_valid_q;
   zt_op_e            op_q;
   zt_order_e         ord_q;
   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_act_q  <= 1'b0;
         pend_valid_q <= 1'b0;
         op_q         <= OP_READ;
         ord_q        <= ORD_LINEAR;
         base_q       <= '0;
         beat_q       <= '0;
      end else if (step) begin
         if (load) begin
            burst_act_q  <= sel;
            pend_valid_q <= sel;
            if (sel) begin
               op_q   <= op_in;
               ord_q  <= ord_in;
               base_q <= addr_in;
               beat_q <= '0;
            end
         end else if (burst_act_q) begin
            pend_valid_q <= 1'b1;
            beat_q       <= beat_q + 1'b1;
         end else begin
            pend_valid_q <= 1'b0;
         end
      end
   end

   assign pend_valid = pend_valid_q;
   assign pend_op    = op_q;
   assign pend_addr  = {base_q[ADDR_W-1:BEAT_W],
                        beat_offset(base_q[BEAT_W-1:0], beat_q, ord_q)};

endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 9,
   localparam int unsigned DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && !lane_wr_n[g])
            mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[addr];
   end

endmodule

// File: rtl/zt_out_stage.sv
module zt_out_stage
   import zt_sram_pkg::*;
#(
   parameter int unsigned DATA_W = 18
) (
   input  logic              pend_valid,
   input  zt_op_e            pend_op,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   always_comb begin
      dout_en = pend_valid && (pend_op == OP_READ) && !oe_n;
      dout    = dout_en ? rdata : '0;
   end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 9,
   parameter int unsigned ADDR_W = $clog2(DEPTH),
   parameter int unsigned DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_n,
   input  logic              ce_a_n,
   input  logic              ce_b,
   input  logic              ce_c_n,
   input  logic              adv_ld,
   input  logic              rd_wr_n,
   input  logic              burst_il,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   if (DEPTH != (1 << ADDR_W)) begin : g_chk_depth
      $error("zt_sram: DEPTH must equal 2**ADDR_W");
   end
   if (ADDR_W <= BEAT_W) begin : g_chk_addr
      $error("zt_sram: ADDR_W must exceed the burst counter width");
   end
   if (DATA_W != LANES * LANE_W) begin : g_chk_data
      $error("zt_sram: DATA_W must equal LANES*LANE_W");
   end

   logic              step;
   logic              selected;
   logic              pend_valid;
   zt_op_e            pend_op;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] rdata;
   logic              commit;

   assign step     = !clk_en_n;
   assign selected = !ce_a_n && ce_b && !ce_c_n;
   assign commit   = step && pend_valid && (pend_op == OP_WRITE);

   zt_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .load       (!adv_ld),
      .sel        (selected),
      .op_in      (rd_wr_n ? OP_READ : OP_WRITE),
      .ord_in     (burst_il ? ORD_INTERLEAVE : ORD_LINEAR),
      .addr_in    (addr),
      .pend_valid (pend_valid),
      .pend_op    (pend_op),
      .pend_addr  (pend_addr)
   );

   zt_lane_array #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_array (
      .clk       (clk),
      .wr_en     (commit),
      .lane_wr_n (lane_wr_n),
      .addr      (pend_addr),
      .wdata     (din),
      .rdata     (rdata)
   );

   zt_out_stage #(.DATA_W(DATA_W)) u_out (
      .pend_valid (pend_valid),
      .pend_op    (pend_op),
      .oe_n       (oe_n),
      .rdata      (rdata),
      .dout       (dout),
      .dout_en    (dout_en)
   );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
   parameter int unsigned DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              ce_a_n,
   input logic              ce_b,
   input logic              ce_c_n,
   input logic              adv_ld,
   input logic              rd_wr_n,
   input logic              oe_n,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en
);

   logic pin_sel;
   assign pin_sel = !ce_a_n && ce_b && !ce_c_n;

   assert_rd_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld && pin_sel && rd_wr_n) |=> (oe_n || dout_en));

   assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> (!$stable(oe_n) || ($stable(dout) && $stable(dout_en))));

   assert_wr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld && pin_sel && !rd_wr_n) |=> !dout_en);

   assert_desel_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld && !pin_sel) |=> !dout_en);

   assert_oe_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!dout_en && dout == '0));

endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_en_n (clk_en_n),
   .ce_a_n   (ce_a_n),
   .ce_b     (ce_b),
   .ce_c_n   (ce_c_n),
   .adv_ld   (adv_ld),
   .rd_wr_n  (rd_wr_n),
   .oe_n     (oe_n),
   .dout     (dout),
   .dout_en  (dout_en)
);

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en_n = 1'b1;
   logic        ce_a_n = 1'b1;
   logic        ce_b = 1'b0;
   logic        ce_c_n = 1'b1;
   logic        adv_ld = 1'b0;
   logic        rd_wr_n = 1'b1;
   logic        burst_il = 1'b0;
   logic [1:0]  lane_wr_n = 2'b11;
   logic [7:0]  addr = '0;
   logic [17:0] din = '0;
   logic        oe_n = 1'b0;
   logic [17:0] dout;
   logic        dout_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   zt_sram u_zt_sram (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
      .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
      .adv_ld(adv_ld), .rd_wr_n(rd_wr_n), .burst_il(burst_il),
      .lane_wr_n(lane_wr_n), .addr(addr), .din(din), .oe_n(oe_n),
      .dout(dout), .dout_en(dout_en)
   );

   // cs field = {ce_a_n, ce_b, ce_c_n}
   localparam logic [2:0] SEL = 3'b010;
   localparam logic [2:0] DES = 3'b110;

   typedef struct packed {
      logic        frz;
      logic        adv;
      logic [2:0]  cs;
      logic        rd;
      logic        il;
      logic [1:0]  bw_n;
      logic [7:0]  addr;
      logic [17:0] din;
      logic        ex_en;
      logic [17:0] ex_do;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,SEL,1'b0,1'b0,2'b11,8'h10,18'h00000,1'b0,18'h00000,4'd6},  // R6 write load
      '{1'b0,1'b0,SEL,1'b0,1'b0,2'b00,8'h11,18'h0A5A5,1'b0,18'h00000,4'd6},  // R6
      '{1'b0,1'b0,SEL,1'b1,1'b0,2'b00,8'h11,18'h3C3C3,1'b1,18'h3C3C3,4'd3},  // R3 read after write
      '{1'b0,1'b0,SEL,1'b0,1'b0,2'b11,8'h10,18'h00000,1'b0,18'h00000,4'd6},  // R3 write after read
      '{1'b0,1'b0,SEL,1'b1,1'b0,2'b10,8'h10,18'h3FFFF,1'b1,18'h0A5FF,4'd2},  // R2 lane 0 only
      '{1'b0,1'b0,DES,1'b1,1'b0,2'b11,8'h00,18'h00000,1'b0,18'h00000,4'd6},  // R6 deselect
      '{1'b0,1'b1,SEL,1'b0,1'b0,2'b00,8'h00,18'h11111,1'b0,18'h00000,4'd10}, // R10 idle advance
      '{1'b0,1'b0,SEL,1'b0,1'b0,2'b11,8'h20,18'h00000,1'b0,18'h00000,4'd6},  // burst write load
      '{1'b0,1'b1,DES,1'b0,1'b0,2'b00,8'h00,18'h00001,1'b0,18'h00000,4'd7},  // R7 cs ignored
      '{1'b0,1'b1,SEL,1'b0,1'b0,2'b00,8'h00,18'h00002,1'b0,18'h00000,4'd8},
      '{1'b0,1'b1,SEL,1'b0,1'b0,2'b00,8'h00,18'h00003,1'b0,18'h00000,4'd8},
      '{1'b0,1'b0,SEL,1'b1,1'b1,2'b00,8'h22,18'h00004,1'b1,18'h00003,4'd9},  // R9 beat 0 (0x22)
      '{1'b0,1'b1,SEL,1'b1,1'b1,2'b11,8'h00,18'h00000,1'b1,18'h00004,4'd9},  // R9 0x23
      '{1'b0,1'b1,SEL,1'b1,1'b1,2'b11,8'h00,18'h00000,1'b1,18'h00001,4'd9},  // R9 0x20
      '{1'b0,1'b1,SEL,1'b1,1'b1,2'b11,8'h00,18'h00000,1'b1,18'h00002,4'd9},  // R9 0x21
      '{1'b0,1'b0,SEL,1'b1,1'b0,2'b11,8'h21,18'h00000,1'b1,18'h00002,4'd8},  // R8 0x21
      '{1'b0,1'b1,SEL,1'b1,1'b0,2'b11,8'h00,18'h00000,1'b1,18'h00003,4'd8},  // R8 0x22
      '{1'b0,1'b1,SEL,1'b1,1'b0,2'b11,8'h00,18'h00000,1'b1,18'h00004,4'd8},  // R8 0x23
      '{1'b0,1'b1,SEL,1'b1,1'b0,2'b11,8'h00,18'h00000,1'b1,18'h00001,4'd8},  // R8 wrap 0x20
      '{1'b0,1'b1,SEL,1'b1,1'b0,2'b11,8'h00,18'h00000,1'b1,18'h00002,4'd8},  // R8 wrap 0x21
      '{1'b1,1'b0,DES,1'b0,1'b0,2'b00,8'h21,18'h3FFFF,1'b1,18'h00002,4'd4},  // R4 freeze
      '{1'b1,1'b0,SEL,1'b0,1'b0,2'b00,8'h10,18'h3FFFF,1'b1,18'h00002,4'd4},  // R4 freeze
      '{1'b0,1'b0,SEL,1'b1,1'b0,2'b00,8'h10,18'h00000,1'b1,18'h0A5FF,4'd10}, // R10 0x10 untouched
      '{1'b0,1'b0,SEL,1'b0,1'b0,2'b11,8'h30,18'h00000,1'b0,18'h00000,4'd6},
      '{1'b0,1'b0,DES,1'b0,1'b0,2'b00,8'h00,18'h2AAAA,1'b0,18'h00000,4'd5},  // R5 deselect
      '{1'b0,1'b0,SEL,1'b1,1'b0,2'b11,8'h30,18'h00000,1'b1,18'h2AAAA,4'd5},  // R5 write completed
      '{1'b0,1'b0,SEL,1'b1,1'b0,2'b11,8'h20,18'h00000,1'b1,18'h00001,4'd1},  // R1 flow-through
      '{1'b0,1'b1,DES,1'b1,1'b0,2'b11,8'h00,18'h00000,1'b1,18'h00002,4'd7},  // R7 read advance
      '{1'b0,1'b0,DES,1'b0,1'b0,2'b11,8'h00,18'h00000,1'b0,18'h00000,4'd6}   // R6
   };

   task automatic check(input int req, input logic ee, input logic [17:0] ed);
      n_checks++;
      if (dout_en !== ee || dout !== ed) begin
         n_fail++;
         $display("FAIL R%0d: dout_en=%0b dout=%05h expected dout_en=%0b dout=%05h",
                  req, dout_en, dout, ee, ed);
      end
   endtask

   task automatic drive(input vec_t v);
      clk_en_n  = v.frz;
      adv_ld    = v.adv;
      {ce_a_n, ce_b, ce_c_n} = v.cs;
      rd_wr_n   = v.rd;
      burst_il  = v.il;
      lane_wr_n = v.bw_n;
      addr      = v.addr;
      din       = v.din;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run still active, expected finish");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(12, 1'b0, 18'h0); // R12 reset state

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(VECS[k]);
         @(posedge clk);
         #1;
         check(int'(VECS[k].req), VECS[k].ex_en, VECS[k].ex_do);
      end

      // R11: asynchronous output enable over a read of 0x23 (holds 4)
      @(negedge clk);
      drive('{1'b0,1'b0,SEL,1'b1,1'b0,2'b11,8'h23,18'h0,1'b0,18'h0,4'd1});
      @(posedge clk);
      #1;
      check(1, 1'b1, 18'h00004);   // R1
      oe_n = 1'b1;
      #0.5;
      check(11, 1'b0, 18'h0);      // R11 off without an edge
      oe_n = 1'b0;
      #0.5;
      check(11, 1'b1, 18'h00004);  // R11 back on

      // R12: reset in the middle of a pending read
      rst_n = 1'b0;
      #0.5;
      check(12, 1'b0, 18'h0);      // R12
      @(negedge clk);
      drive('{1'b0,1'b0,DES,1'b1,1'b0,2'b11,8'h00,18'h0,1'b0,18'h0,4'd12});
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(12, 1'b0, 18'h0);      // R12 stays idle after release
      summary();
   end

endmodule